// File: doc/BRIEF.md
# Burst Bus Initiator and Target Pair

This block joins a bus initiator and a memory-backed target on a synchronous bus that carries the address and the data on the same lines. All control lines are active low. A local request starts a transaction. The initiator then spends one cycle in an address phase, with its frame line low and the start address and a direction bit on the shared lines. After that come data phases. A word moves on each rising edge at which the initiator ready and the target ready are both low. The burst length is given only as a word count. On each completed word the target steps its own address by one word, and the address wraps at the memory depth.

Either side can slow the burst down. The initiator holds its ready high while a stall input is set. The target waits a programmed 0 to 3 cycles before it raises its ready for each word. A read also costs one extra cycle on its first word, because the shared lines are left undriven while ownership passes from the initiator to the target. The initiator raises frame during the final data phase. The target can cut a burst short by asserting stop once a programmed number of words has moved. At the end, a done pulse reports how many words were transferred.

Top module: `burst_bus_pair`

## Requirements
- R1: After reset, frame_n, irdy_n, trdy_n and stop_n are all 1, ad_drv is 00, and busy and done are 0.
- R2: A req_start with req_len of 1 or more while busy is 0 produces an address phase in the next cycle. In that phase frame_n is 0, irdy_n is 1, ad holds req_addr zero-extended, cmd_w equals req_write, and ad_drv is 01. A req_start while busy is 1, or with req_len 0, has no effect.
- R3: A word moves only in a cycle where xfer is 1, that is where irdy_n and trdy_n are both 0. On a write, word k (counted from 0) is the wr_data presented while wr_idx equals k. It is stored at (req_addr + k) mod DEPTH.
- R4: On a read, word k is the memory content at (req_addr + k) mod DEPTH. In the first cycle after the address phase nobody drives ad (ad_drv 00) and trdy_n is 1.
- R5: With target wait setting W sampled at the address phase, and with no stall, word k moves in cycle 1 + W + R + k(W+1) counted from the address phase (cycle 0). R is 1 for a read and 0 for a write.
- R6: While ini_stall is 1 in a data phase, irdy_n is 1 and no word moves. A target whose ready is already low keeps it low.
- R7: frame_n is 1 in a data phase exactly when one transfer remains, so the word that moves with frame_n 1 is the last one.
- R8: With tgt_limit L not 0 and L below req_len, the target asserts stop_n 0 with trdy_n 1 after L words have moved. No word moves then and the transaction ends. With L equal to 0 the target never stops.
- R9: The cycle after the final transfer or the stop has frame_n and irdy_n at 1, busy at 0, and done at 1 for one cycle, with words equal to the number of words moved. At most one agent drives ad in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Burst length in words |
| wr_data | input | DW | Write word for index wr_idx |
| wr_idx | output | LW | Index of the write word now wanted |
| ini_stall | input | 1 | Initiator not ready this cycle |
| tgt_wait | input | 2 | Target wait cycles per word |
| tgt_limit | input | LW | Words the target accepts before stop, 0 = no limit |
| frame_n | output | 1 | Frame line, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| cmd_w | output | 1 | Direction bit in the address phase |
| ad | output | DW | Shared address/data lines, 0 when undriven |
| ad_drv | output | 2 | Driver of ad: bit 0 initiator, bit 1 target |
| xfer | output | 1 | A word moves at the coming edge |
| busy | output | 1 | Initiator in a transaction |
| done | output | 1 | One-cycle end pulse |
| words | output | LW | Words moved in the last transaction |

## Verification
Several rules are checked on every cycle by assertions. These cover the single driver on the shared lines, the undriven cycle after a read address phase, and stop never coming together with target ready. They also cover the target holding its ready through an initiator stall and the return of frame and initiator ready to idle after the last word or a stop. Other behaviours can only be shown by the bench scenarios, which compare against a behavioural memory model. These are the data values and their wrapped addresses, the exact cycle of each word for each wait setting, the word count at a stop, and the proof that a disconnected write left the later locations untouched.

// File: rtl/burst_bus_pair.sv
module burst_bus_pair #(
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int LW = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] wr_data,
  output logic [LW-1:0] wr_idx,
  input  logic          ini_stall,
  input  logic [1:0]    tgt_wait,
  input  logic [LW-1:0] tgt_limit,
  output logic          frame_n,
  output logic          irdy_n,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          cmd_w,
  output logic [DW-1:0] ad,
  output logic [1:0]    ad_drv,
  output logic          xfer,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] words
);

  typedef enum logic [1:0] {I_IDLE, I_ADDR, I_DATA} ist_t;

  ist_t          ist;
  logic          i_write;
  logic [AW-1:0] i_addr;
  logic [LW-1:0] i_rem, i_cnt;

  logic          t_act, t_write, t_tar;
  logic [AW-1:0] t_addr;
  logic [2:0]    t_wcnt;
  logic [1:0]    t_wset;
  logic [LW-1:0] t_cnt, t_lim;
  logic [DW-1:0] mem [DEPTH];

  logic i_data, t_stop;

  assign i_data  = (ist == I_DATA);
  assign t_stop  = t_act && (t_wcnt == 3'd0) && (t_lim != '0) && (t_cnt == t_lim);
  assign frame_n = !((ist == I_ADDR) || (i_data && i_rem != LW'(1)));
  assign irdy_n  = !(i_data && !ini_stall);
  assign trdy_n  = !(t_act && (t_wcnt == 3'd0) && !t_stop);
  assign stop_n  = !t_stop;
  assign xfer    = !irdy_n && !trdy_n;
  assign cmd_w   = (ist == I_ADDR) && i_write;
  assign busy    = (ist != I_IDLE);
  assign wr_idx  = i_cnt;

  assign ad_drv[0] = (ist == I_ADDR) || (i_data && i_write);
  assign ad_drv[1] = t_act && !t_write && !t_tar;

  always_comb begin
    if (ist == I_ADDR)  ad = {{(DW-AW){1'b0}}, i_addr};
    else if (ad_drv[0]) ad = wr_data;
    else if (ad_drv[1]) ad = mem[t_addr];
    else                ad = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist     <= I_IDLE;
      i_write <= 1'b0;
      i_addr  <= '0;
      i_rem   <= '0;
      i_cnt   <= '0;
      done    <= 1'b0;
      words   <= '0;
    end else begin
      done <= 1'b0;
      case (ist)
        I_IDLE: if (req_start && req_len != '0) begin
          ist     <= I_ADDR;
          i_write <= req_write;
          i_addr  <= req_addr;
          i_rem   <= req_len;
          i_cnt   <= '0;
        end
        I_ADDR: ist <= I_DATA;
        default: begin
          if (!stop_n) begin
            ist   <= I_IDLE;
            done  <= 1'b1;
            words <= i_cnt;
          end else if (xfer) begin
            i_cnt <= i_cnt + LW'(1);
            i_rem <= i_rem - LW'(1);
            if (i_rem == LW'(1)) begin
              ist   <= I_IDLE;
              done  <= 1'b1;
              words <= i_cnt + LW'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_act   <= 1'b0;
      t_write <= 1'b0;
      t_tar   <= 1'b0;
      t_addr  <= '0;
      t_wcnt  <= '0;
      t_wset  <= '0;
      t_cnt   <= '0;
      t_lim   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (!t_act) begin
      if (!frame_n) begin
        t_act   <= 1'b1;
        t_addr  <= ad[AW-1:0];
        t_write <= cmd_w;
        t_tar   <= !cmd_w;
        t_wset  <= tgt_wait;
        t_wcnt  <= 3'(tgt_wait) + 3'(!cmd_w);
        t_cnt   <= '0;
        t_lim   <= tgt_limit;
      end
    end else begin
      t_tar <= 1'b0;
      if (t_stop) begin
        t_act <= 1'b0;
      end else if (xfer) begin
        if (t_write) mem[t_addr] <= ad;
        t_addr <= t_addr + AW'(1);
        t_cnt  <= t_cnt + LW'(1);
        t_wcnt <= 3'(t_wset);
        if (frame_n) t_act <= 1'b0;
      end else if (t_wcnt != 3'd0) begin
        t_wcnt <= t_wcnt - 3'd1;
      end
    end
  end

  assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ad_drv));

  assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (ad_drv == 2'b01) && irdy_n);

  assert_read_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && !cmd_w) |=> (ad_drv == 2'b00) && trdy_n);

  assert_stall_holds_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> !trdy_n);

  assert_last_word_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_n) |=> frame_n && irdy_n && done);

  assert_stop_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> trdy_n);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |=> frame_n && irdy_n && !busy && done);

endmodule

// File: tb/burst_bus_pair_test.sv
`timescale 1ns/1ps
module burst_bus_pair_test;
  localparam int DW = 32, DEPTH = 16, LW = 5, AW = 4;

  logic clk = 0, rst_n = 0;
  logic req_start = 0, req_write = 0, ini_stall = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0, tgt_limit = '0, wr_idx, words;
  logic [1:0] tgt_wait = '0, ad_drv;
  logic [DW-1:0] wr_data, ad;
  logic frame_n, irdy_n, trdy_n, stop_n, cmd_w, xfer, busy, done;
  logic [7:0] seed = '0;
  logic [DW-1:0] mm [DEPTH];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign wr_data = {8'hC3, seed, 11'd0, wr_idx};

  burst_bus_pair #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_idx(wr_idx),
    .ini_stall(ini_stall), .tgt_wait(tgt_wait), .tgt_limit(tgt_limit),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .cmd_w(cmd_w), .ad(ad), .ad_drv(ad_drv), .xfer(xfer), .busy(busy),
    .done(done), .words(words));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit wr, input int addr, input int len, input int w,
                     input int lim, input bit stall, input logic [7:0] sd, input bit poke);
    int n, rd, k, last;
    bit fin;
    logic [DW-1:0] exp;
    rd = wr ? 0 : 1;
    n = (lim != 0 && lim < len) ? lim : len;
    @(negedge clk);
    req_write = wr; req_addr = AW'(addr); req_len = LW'(len);
    tgt_wait = 2'(w); tgt_limit = LW'(lim); seed = sd; req_start = 1; ini_stall = 0;
    @(negedge clk);
    req_start = 0;
    #1;
    chk(frame_n == 0 && irdy_n == 1 && ad == DW'(addr) && cmd_w == wr && ad_drv == 2'b01,
        "R2 address phase", {frame_n, cmd_w, ad_drv}, {1'b0, wr, 2'b01});
    k = 0; fin = 0; last = 0;
    for (int j = 1; j < 300 && !fin; j++) begin
      @(negedge clk);
      if (poke && j == 2) begin
        req_start = 1; req_write = !wr; req_addr = AW'(addr + 5); req_len = 3;
      end else req_start = 0;
      ini_stall = stall && (j % 3 == 1);
      #1;
      if (j == 1 && !wr)
        chk(ad_drv == 2'b00 && trdy_n, "R4 turnaround", ad_drv, 0);
      if (ini_stall)
        chk(!xfer && irdy_n, "R6 stall blocks transfer", xfer, 0);
      if (xfer) begin
        if (wr) begin
          exp = {8'hC3, sd, 11'd0, 5'(k)};
          chk(ad == exp, "R3 write word", ad, exp);
          mm[(addr + k) % DEPTH] = exp;
        end else begin
          exp = mm[(addr + k) % DEPTH];
          chk(ad == exp, "R4 read word", ad, exp);
        end
        if (!stall) chk(j == 1 + w + rd + k * (w + 1), "R5 word timing", j, 1 + w + rd + k * (w + 1));
        chk(frame_n == (k == len - 1), "R7 frame on last word", frame_n, k == len - 1);
        k++;
        last = j;
      end
      if (!stop_n) begin
        chk(lim != 0 && k == lim && trdy_n, "R8 stop point", k, lim);
        if (!stall) chk(j == 1 + w + rd + lim * (w + 1), "R8 stop timing", j, 1 + w + rd + lim * (w + 1));
        last = j;
      end
      if (done) begin
        chk(words == LW'(n) && k == n, "R9 word count", words, n);
        chk(frame_n && irdy_n && !busy && j == last + 1, "R9 end state", j, last + 1);
        fin = 1;
      end
    end
    if (!fin) chk(0, "R9 transaction never ended", k, n);
    ini_stall = 0; req_start = 0;
    repeat (3) begin
      @(negedge clk); #1;
      if (poke) chk(!busy && frame_n, "R2 start while busy ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(frame_n && irdy_n && trdy_n && stop_n && ad_drv == 0 && !busy && !done,
        "R1 reset state", {frame_n, irdy_n, trdy_n, stop_n}, 4'hF);
    rst_n = 1;
    @(negedge clk); #1;
    chk(frame_n && irdy_n && trdy_n && stop_n && !busy, "R1 idle after reset", busy, 0);

    run(1, 3, 4, 0, 0, 0, 8'h11, 0);
    run(0, 3, 4, 0, 0, 0, 8'h00, 0);
    run(1, 14, 5, 2, 0, 0, 8'h22, 1);
    run(0, 14, 5, 1, 0, 0, 8'h00, 0);
    run(0, 13, 3, 3, 0, 0, 8'h00, 0);
    run(1, 0, 6, 1, 0, 1, 8'h33, 0);
    run(0, 0, 6, 0, 0, 1, 8'h00, 0);
    run(1, 8, 6, 1, 2, 0, 8'h44, 0);
    run(0, 8, 6, 0, 0, 0, 8'h00, 0);
    run(0, 7, 5, 0, 3, 0, 8'h00, 0);
    run(0, 5, 1, 0, 0, 0, 8'h00, 0);
    run(1, 9, 1, 3, 0, 0, 8'h55, 0);

    @(negedge clk);
    req_len = 0; req_write = 1; req_start = 1;
    @(negedge clk);
    req_start = 0; #1;
    chk(frame_n && !busy && ad_drv == 0, "R2 zero length ignored", busy, 0);
    @(negedge clk); #1;
    chk(frame_n && !busy, "R2 zero length stays idle", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule